// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a bank of general-purpose pins with a synchronous register port. Each pin can be driven from an output data bit when its output-enable bit is set. It can be read back through a two-flop synchronizer. Optionally, the pin can pass through a debounce filter. All filtered pins share one divider value, and each pin has its own bit that turns its filter on or off. Output data and output enable can be written whole, or changed bit by bit through write-ones set and clear ports, so software needs no read-modify-write sequence.

The filtered level of each pin feeds an edge detector. Rising and falling edges are enabled separately for each pin. An enabled edge sets a sticky pending bit, which stays set until software writes a one to it. A single interrupt line is high while any pending bit is set. The block also produces pull-up and pull-down control for each pin. These come from a pull-enable bit and a direction bit.

Register reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high. Every register resets to zero, so each pin starts as an input with interrupts, pulls and filtering off.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, pin_out, pin_oe, pull_up, pull_dn and irq are all zero, and the divider register (0x48) reads zero.
- R2: Whole-register writes and reads work at these byte addresses: output data 0x10, output enable 0x04, debounce enable 0x24, rising enable 0x28, falling enable 0x2C, pull enable 0x50, pull direction 0x54. Any unmapped address, for example 0x40, reads zero.
- R3: Writing to 0x14 sets the output data bits where the written word has ones. Writing to 0x1C does the same for the output-enable bits. Zero bits leave their targets unchanged.
- R4: Writing to 0x18 clears the output data bits where the written word has ones. Writing to 0x20 does the same for the output-enable bits. Zero bits leave their targets unchanged.
- R5: Address 0x00 reads the filtered input level of all pins. With debounce off, a pin change driven before clock edge k is readable after edge k+1.
- R6: The divider is bits 29:16 of 0x48, and all other bits of that register read zero. With a divider value D, a filtered pin ignores a level change that lasts fewer than D+1 cycles. It takes up a change held steady for longer than 2(D+1)+3 cycles.
- R7: The debounce enable at 0x24 (bit n for pin n) affects only its own pin. Pins whose bit is clear follow the synchronizer directly.
- R8: An enabled rising edge sets the pin's bit in 0x30, and an enabled falling edge sets it in 0x34. The bit is set one cycle after the new level becomes readable at 0x00. Address 0x0C reads the OR of 0x30 and 0x34.
- R9: An edge on a pin whose matching enable bit is clear sets no pending bit.
- R10: Writing ones to 0x0C clears those bits in both 0x30 and 0x34, and zero bits change nothing. A pending bit stays set after its enable is removed.
- R11: When a new enabled edge and a clear of the same bit land on the same clock edge, the new edge wins and the bit stays set.
- R12: irq is high exactly while at least one pending bit is set.
- R13: pull_up[n] is pull-enable[n] AND direction[n], and pull_dn[n] is pull-enable[n] AND NOT direction[n]. Direction 1 means up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | N_PINS | Asynchronous pin levels |
| pin_out | output | N_PINS | Output data |
| pin_oe | output | N_PINS | Output enable, 1 means drive |
| pull_up | output | N_PINS | Pull-up request |
| pull_dn | output | N_PINS | Pull-down request |
| irq | output | 1 | High while any pending bit is set |

## Verification
Register effects appear one edge after the write strobe, so the bench reads them at the following falling edge. A pin change driven at a falling edge becomes readable at 0x00 two falling edges later, and its pending bit and irq appear one falling edge after that. Each check waits exactly that many falling edges before it places its expected value in the scoreboard queue. The same-edge clear case puts the acknowledge strobe on the very edge where the edge detector fires. Debounce checks allow margins of whole divider periods on both sides rather than exact cycles, because the shared divider phase is free-running.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int DIV_LSB = 16;
  localparam int DIV_W = 14;

  typedef logic [DATA_W-1:0] word_t;

  localparam logic [ADDR_W-1:0] A_LEVEL      = 8'h00;
  localparam logic [ADDR_W-1:0] A_DRIVE_EN   = 8'h04;
  localparam logic [ADDR_W-1:0] A_PEND_ALL   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_DATA       = 8'h10;
  localparam logic [ADDR_W-1:0] A_DATA_SET   = 8'h14;
  localparam logic [ADDR_W-1:0] A_DATA_CLR   = 8'h18;
  localparam logic [ADDR_W-1:0] A_DRIVE_SET  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_DRIVE_CLR  = 8'h20;
  localparam logic [ADDR_W-1:0] A_FILT_EN    = 8'h24;
  localparam logic [ADDR_W-1:0] A_RISE_EN    = 8'h28;
  localparam logic [ADDR_W-1:0] A_FALL_EN    = 8'h2C;
  localparam logic [ADDR_W-1:0] A_PEND_RISE  = 8'h30;
  localparam logic [ADDR_W-1:0] A_PEND_FALL  = 8'h34;
  localparam logic [ADDR_W-1:0] A_DIVIDER    = 8'h48;
  localparam logic [ADDR_W-1:0] A_PULL_EN    = 8'h50;
  localparam logic [ADDR_W-1:0] A_PULL_DIR   = 8'h54;

  // Bitwise set/clear update used for data and drive-enable ports.
  function automatic word_t apply_set_clr(word_t cur, word_t set_m, word_t clr_m);
    return (cur | set_m) & ~clr_m;
  endfunction

  // New edges override a same-cycle acknowledge.
  function automatic word_t pend_update(word_t cur, word_t hit, word_t ack);
    return (cur & ~ack) | hit;
  endfunction

  function automatic word_t pull_up_of(word_t en, word_t dir);
    return en & dir;
  endfunction

  function automatic word_t pull_dn_of(word_t en, word_t dir);
    return en & ~dir;
  endfunction
endpackage

// File: rtl/gpio_div_tick.sv
module gpio_div_tick #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] limit,
  output logic          tick
);
  logic [CW-1:0] cnt_q;

  // Compare with >= so a lowered limit never waits for a full wrap.
  assign tick = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] filt_en,
  input  logic         tick,
  output logic [W-1:0] level
);
  logic [W-1:0] meta_q, sync_q, held_q, arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    // A differing level must survive two divider ticks before it is taken.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q[i] <= 1'b0;
        arm_q[i]  <= 1'b0;
      end else if (!filt_en[i] || (sync_q[i] == held_q[i])) begin
        held_q[i] <= sync_q[i];
        arm_q[i]  <= 1'b0;
      end else if (tick) begin
        if (arm_q[i]) begin
          held_q[i] <= sync_q[i];
          arm_q[i]  <= 1'b0;
        end else begin
          arm_q[i]  <= 1'b1;
        end
      end
    end
    assign level[i] = filt_en[i] ? held_q[i] : sync_q[i];
  end
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend
  import gpio_edge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] ack_rise,
  input  logic [W-1:0] ack_fall,
  output logic [W-1:0] rise_hit,
  output logic [W-1:0] fall_hit,
  output logic [W-1:0] rise_p,
  output logic [W-1:0] fall_p
);
  logic [W-1:0] prev_q;

  assign rise_hit = level & ~prev_q & rise_en;
  assign fall_hit = ~level & prev_q & fall_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      rise_p <= '0;
      fall_p <= '0;
    end else begin
      prev_q <= level;
      rise_p <= W'(pend_update(word_t'(rise_p), word_t'(rise_hit), word_t'(ack_rise)));
      fall_p <= W'(pend_update(word_t'(fall_p), word_t'(fall_hit), word_t'(ack_fall)));
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic [N_PINS-1:0] pull_up,
  output logic [N_PINS-1:0] pull_dn,
  output logic              irq
);
  localparam int PW = N_PINS;

  logic [PW-1:0] data_q, drive_q, filt_q, rise_en_q, fall_en_q, pen_q, pdir_q;
  logic [DIV_W-1:0] div_q;
  logic [PW-1:0] level, rise_hit, fall_hit, rise_p, fall_p, ack_rise, ack_fall;
  logic [PW-1:0] wbits;
  logic div_tick;

  assign wbits = bus_wdata[PW-1:0];

  // Acknowledge masks, brought out for the checker.
  assign ack_rise = (bus_wr && (bus_addr == A_PEND_ALL || bus_addr == A_PEND_RISE)) ? wbits : '0;
  assign ack_fall = (bus_wr && (bus_addr == A_PEND_ALL || bus_addr == A_PEND_FALL)) ? wbits : '0;

  gpio_div_tick #(.CW(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .limit(div_q), .tick(div_tick)
  );

  gpio_in_filter #(.W(PW)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(pin_in), .filt_en(filt_q),
    .tick(div_tick), .level(level)
  );

  gpio_edge_pend #(.W(PW)) u_pend (
    .clk(clk), .rst_n(rst_n), .level(level),
    .rise_en(rise_en_q), .fall_en(fall_en_q),
    .ack_rise(ack_rise), .ack_fall(ack_fall),
    .rise_hit(rise_hit), .fall_hit(fall_hit),
    .rise_p(rise_p), .fall_p(fall_p)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      drive_q   <= '0;
      filt_q    <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      pen_q     <= '0;
      pdir_q    <= '0;
      div_q     <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:      data_q    <= wbits;
        A_DATA_SET:  data_q    <= PW'(apply_set_clr(word_t'(data_q), word_t'(wbits), '0));
        A_DATA_CLR:  data_q    <= PW'(apply_set_clr(word_t'(data_q), '0, word_t'(wbits)));
        A_DRIVE_EN:  drive_q   <= wbits;
        A_DRIVE_SET: drive_q   <= PW'(apply_set_clr(word_t'(drive_q), word_t'(wbits), '0));
        A_DRIVE_CLR: drive_q   <= PW'(apply_set_clr(word_t'(drive_q), '0, word_t'(wbits)));
        A_FILT_EN:   filt_q    <= wbits;
        A_RISE_EN:   rise_en_q <= wbits;
        A_FALL_EN:   fall_en_q <= wbits;
        A_PULL_EN:   pen_q     <= wbits;
        A_PULL_DIR:  pdir_q    <= wbits;
        A_DIVIDER:   div_q     <= bus_wdata[DIV_LSB +: DIV_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LEVEL:     bus_rdata = DATA_W'(level);
      A_DRIVE_EN:  bus_rdata = DATA_W'(drive_q);
      A_PEND_ALL:  bus_rdata = DATA_W'(rise_p | fall_p);
      A_DATA:      bus_rdata = DATA_W'(data_q);
      A_FILT_EN:   bus_rdata = DATA_W'(filt_q);
      A_RISE_EN:   bus_rdata = DATA_W'(rise_en_q);
      A_FALL_EN:   bus_rdata = DATA_W'(fall_en_q);
      A_PEND_RISE: bus_rdata = DATA_W'(rise_p);
      A_PEND_FALL: bus_rdata = DATA_W'(fall_p);
      A_DIVIDER:   bus_rdata[DIV_LSB +: DIV_W] = div_q;
      A_PULL_EN:   bus_rdata = DATA_W'(pen_q);
      A_PULL_DIR:  bus_rdata = DATA_W'(pdir_q);
      default:     bus_rdata = '0;
    endcase
  end

  assign pin_out = data_q;
  assign pin_oe  = drive_q;
  assign pull_up = PW'(pull_up_of(word_t'(pen_q), word_t'(pdir_q)));
  assign pull_dn = PW'(pull_dn_of(word_t'(pen_q), word_t'(pdir_q)));
  assign irq     = |(rise_p | fall_p);
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe,
  input logic              irq,
  input logic [N_PINS-1:0] rise_p,
  input logic [N_PINS-1:0] fall_p,
  input logic [N_PINS-1:0] rise_hit,
  input logic [N_PINS-1:0] fall_hit,
  input logic [N_PINS-1:0] ack_rise,
  input logic [N_PINS-1:0] ack_fall
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq));

  p_data_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA_SET) |=>
      ((pin_out & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  p_drive_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DRIVE_SET) |=>
      ((pin_oe & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0])));

  p_data_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA_CLR) |=>
      ((pin_out & $past(bus_wdata[N_PINS-1:0])) == '0));

  p_drive_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DRIVE_CLR) |=>
      ((pin_oe & $past(bus_wdata[N_PINS-1:0])) == '0));

  p_rise_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rise_p) & ~$past(ack_rise)) & ~rise_p) == '0));

  p_fall_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(fall_p) & ~$past(ack_fall)) & ~fall_p) == '0));

  p_rise_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((rise_p & ~$past(rise_p)) & ~$past(rise_hit)) == '0));

  p_fall_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((fall_p & ~$past(fall_p)) & ~$past(fall_hit)) == '0));

  p_edge_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fall_hit & ack_fall)) |=>
      ((fall_p & $past(fall_hit & ack_fall)) == $past(fall_hit & ack_fall)));

  p_irq_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(rise_hit | fall_hit)));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .rise_p(rise_p), .fall_p(fall_p), .rise_hit(rise_hit), .fall_hit(fall_hit),
  .ack_rise(ack_rise), .ack_fall(ack_fall)
);

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;
  localparam int CLK_NS = 20;
  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pull_up, pull_dn;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 pin_out, 2 pin_oe, 3 pull_up, 4 pull_dn, 5 irq
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_NS/2) clk = ~clk;

  gpio_edge_bank #(.N_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up),
    .pull_dn(pull_dn), .irq(irq)
  );

  // Monitor: pops expected items and compares against the live outputs.
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = bus_rdata;
          1: act = pin_out;
          2: act = pin_oe;
          3: act = pull_up;
          4: act = pull_dn;
          default: act = {31'b0, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s act=%h exp=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #2;
    push(0, e, tag);
    #1;
  endtask

  task automatic exp_port(input int kind, input logic [31:0] e, input string tag);
    @(negedge clk);
    #2;
    push(kind, e, tag);
    #1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    exp_port(1, 32'h0, "R1 pin_out after reset");
    exp_port(2, 32'h0, "R1 pin_oe after reset");
    exp_port(3, 32'h0, "R1 pull_up after reset");
    exp_port(5, 32'h0, "R1 irq after reset");
    exp_rd(8'h48, 32'h0, "R1 divider after reset");

    // R2 whole-register access
    wr(8'h10, 32'hA5A5_0F0F);
    exp_rd(8'h10, 32'hA5A5_0F0F, "R2 data readback");
    wr(8'h04, 32'h0000_FFFF);
    exp_rd(8'h04, 32'h0000_FFFF, "R2 drive enable readback");
    exp_rd(8'h40, 32'h0, "R2 unmapped reads zero");

    // R3 set ports
    wr(8'h14, 32'hF000_0000);
    exp_port(1, 32'hF5A5_0F0F, "R3 data set");
    wr(8'h1C, 32'hFF00_0000);
    exp_port(2, 32'hFF00_FFFF, "R3 drive set");

    // R4 clear ports
    wr(8'h18, 32'h0000_000F);
    exp_port(1, 32'hF5A5_0F00, "R4 data clear");
    wr(8'h20, 32'h0000_00FF);
    exp_port(2, 32'hFF00_FF00, "R4 drive clear");

    // R13 pulls
    wr(8'h50, 32'h0000_00FF);
    wr(8'h54, 32'h0000_000F);
    exp_port(3, 32'h0000_000F, "R13 pull up");
    exp_port(4, 32'h0000_00F0, "R13 pull down");

    // R5 input read, R9 no pending without enables
    @(negedge clk);
    pin_in = 32'h1234_5678;
    @(negedge clk);
    exp_rd(8'h00, 32'h1234_5678, "R5 input level after two edges");
    cyc(2);
    exp_rd(8'h0C, 32'h0, "R9 edges with enables off");
    @(negedge clk);
    pin_in = '0;
    cyc(4);

    // R8 edge pending
    wr(8'h28, 32'h0000_0011);
    wr(8'h2C, 32'h0000_0012);
    @(negedge clk);
    pin_in = 32'h0000_0013;
    cyc(2);
    exp_rd(8'h30, 32'h0000_0011, "R8 rising pending");
    exp_rd(8'h34, 32'h0, "R8 falling pending empty");
    exp_port(5, 32'h1, "R12 irq with pending");
    @(negedge clk);
    pin_in = '0;
    cyc(2);
    exp_rd(8'h34, 32'h0000_0012, "R8 falling pending");
    exp_rd(8'h0C, 32'h0000_0013, "R8 combined pending");

    // R10 acknowledge and stickiness
    wr(8'h0C, 32'h0000_0001);
    exp_rd(8'h0C, 32'h0000_0012, "R10 partial acknowledge");
    exp_rd(8'h30, 32'h0000_0010, "R10 rising after ack");
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
    exp_rd(8'h0C, 32'h0000_0012, "R10 sticky after disable");
    wr(8'h0C, 32'h0000_0012);
    exp_rd(8'h0C, 32'h0, "R10 full acknowledge");
    exp_port(5, 32'h0, "R12 irq low when clear");

    // R11 edge beats same-edge clear
    wr(8'h28, 32'h0000_0004);
    wr(8'h2C, 32'h0000_0004);
    @(negedge clk);
    pin_in = 32'h0000_0004;
    cyc(3);
    exp_rd(8'h30, 32'h0000_0004, "R11 setup rising pending");
    @(negedge clk);
    pin_in = '0;
    @(negedge clk);
    wr(8'h0C, 32'h0000_0004);
    exp_rd(8'h34, 32'h0000_0004, "R11 falling kept over clear");
    exp_rd(8'h30, 32'h0, "R11 rising cleared");
    exp_port(5, 32'h1, "R11 irq stays");
    wr(8'h0C, 32'h0000_0004);
    wr(8'h28, 32'h0);
    wr(8'h2C, 32'h0);
    exp_port(5, 32'h0, "R12 irq after final clear");

    // R6 divider field
    wr(8'h48, 32'hFFFF_FFFF);
    exp_rd(8'h48, 32'h3FFF_0000, "R6 divider field mask");
    wr(8'h48, 32'h0014_0000);
    wr(8'h24, 32'h0000_0100);
    cyc(3);

    // R6/R7 glitch: filtered pin 8 ignores it, unfiltered pin 9 shows it
    @(negedge clk);
    pin_in = 32'h0000_0300;
    @(negedge clk);
    exp_rd(8'h00, 32'h0000_0200, "R7 unfiltered pin follows glitch");
    pin_in = '0;
    cyc(60);
    exp_rd(8'h00, 32'h0, "R6 short glitch rejected");

    // R6 steady level accepted only after a full period
    @(negedge clk);
    pin_in = 32'h0000_0100;
    cyc(10);
    exp_rd(8'h00, 32'h0, "R6 not yet accepted");
    cyc(60);
    exp_rd(8'h00, 32'h0000_0100, "R6 steady level accepted");

    cyc(2);
    wait (sb_q.size() == 0);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule